// File: doc/BRIEF.md
# Root Hub Port Connect and Change Tracker

This block keeps the status word of every downstream port of a USB host root hub. Each port watches an already-debounced attach signal and a low-speed indication. From them it keeps a current-connect bit, a connect-change flag, a port-enabled bit, an enable-change flag and a low-speed bit. Software reads one port's word at a time through a small register interface. It writes 1 to a change flag to clear it, and it writes the enable and suspend bits directly.

A host-reset level from the command block acts on every port at once. While it is high, each port reports a disconnect even if a device is still plugged in. The port drops its enable, and the change flags record what was lost. A shared bit-time tick then counts out a fixed quiet period after the reset ends. Only when that period is over does each port sample the live inputs again and report the device that is really attached.

Top module: `rh_port_bank`

## Requirements
- R1: After the synchronous reset every port word reads 0x0000.
- R2: Outside host reset and the quiet period, a change of a port's attach input shows in bit 0 one cycle later, and bit 1 is set to 1.
- R3: When an enabled port loses its attach input, bit 2 is cleared and bit 3 is set in the same update.
- R4: Writing 1 to bit 1 or to bit 3 clears that flag. Writing 0 to either bit leaves it unchanged.
- R5: A write stores bit 2 (port enabled) from the write data, but a 1 is accepted only while bit 0 is 1. Writing 0 clears the bit.
- R6: While host reset is high, bits 0, 2 and 8 are forced to 0. Bit 1 is set if the port was connected, and bit 3 is set if it was enabled.
- R7: Bit 12 (suspend, read/write by software) and the bits outside 8 and 3:0 keep their values through a host reset.
- R8: After host reset falls, bits 0 and 8 stay 0 until the 64th bit-time tick. On the cycle of that tick the live inputs are sampled, and they show one cycle later.
- R9: A host reset that arrives during the quiet period restarts the 64-tick count from zero.
- R10: Bit 8 shows the low-speed input while the port is attached, and it reads 0 while the port is detached.
- R11: The address picks the port (0 to N-1). A write changes only the addressed port, and a read from an address of N or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rst | input | 1 | Host controller reset level from the command block |
| bit_tick | input | 1 | One-cycle pulse per USB bit time |
| attach_in | input | NUM_PORTS | Debounced attach signal, one per port |
| lowspd_in | input | NUM_PORTS | Low-speed device indication, one per port |
| reg_addr | input | ADDR_W | Port select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Status word of the addressed port (combinational) |

## Verification
The bench builds the block with three ports and the default 64-tick quiet period. With three ports the two-bit address has one unused code, so the zero read from an unused address can be tested. Port 0 carries the reset and re-detect sequences, and ports 1 and 2 show that writes and attach changes stay with their own port. Because the quiet period is the full 64 ticks, the tests can check the last tick before release and the tick of release, and can place a second reset in the middle of the count.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int WORD_W  = 16;
    localparam int B_CONN  = 0;
    localparam int B_CSC   = 1;
    localparam int B_EN    = 2;
    localparam int B_PEC   = 3;
    localparam int B_LS    = 8;
    localparam int B_SUSP  = 12;

    typedef struct packed {
        logic susp;
        logic ls;
        logic pec;
        logic en;
        logic csc;
        logic conn;
    } port_st_t;

    typedef enum logic [1:0] {
        TM_LIVE = 2'd0,
        TM_HOLD = 2'd1,
        TM_WAIT = 2'd2
    } tm_state_t;

    function automatic logic [WORD_W-1:0] to_word(port_st_t s);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[B_CONN] = s.conn;
        w[B_CSC]  = s.csc;
        w[B_EN]   = s.en;
        w[B_PEC]  = s.pec;
        w[B_LS]   = s.ls;
        w[B_SUSP] = s.susp;
        return w;
    endfunction

endpackage

// File: rtl/rh_redetect_timer.sv
module rh_redetect_timer
    import rh_port_pkg::*;
#(
    parameter int DETECT_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic host_rst,
    input  logic bit_tick,
    output logic sample_en
);
    localparam int CNT_W = $clog2(DETECT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DETECT_TICKS - 1);

    tm_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic             last_tick;

    assign last_tick = (state == TM_WAIT) && bit_tick && (cnt == LAST);
    assign sample_en = !host_rst && ((state == TM_LIVE) || last_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TM_LIVE;
            cnt   <= '0;
        end else if (host_rst) begin
            state <= TM_HOLD;
            cnt   <= '0;
        end else begin
            case (state)
                TM_HOLD: begin
                    state <= TM_WAIT;
                    cnt   <= '0;
                end
                TM_WAIT: begin
                    if (bit_tick) begin
                        if (cnt == LAST) begin
                            state <= TM_LIVE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= TM_LIVE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        host_rst |=> (state == TM_HOLD) && (cnt == '0));
    p_no_sample_in_reset_r6: assert property (@(posedge clk) disable iff (rst)
        host_rst |-> !sample_en);

endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
    import rh_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rst,
    input  logic              sample_en,
    input  logic              attach,
    input  logic              lowspd,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    output port_st_t          st
);
    port_st_t nx;

    always_comb begin
        nx = st;
        if (wr_sel) begin
            if (wdata[B_CSC]) nx.csc = 1'b0;
            if (wdata[B_PEC]) nx.pec = 1'b0;
            nx.en   = wdata[B_EN] & st.conn;
            nx.susp = wdata[B_SUSP];
        end
        if (host_rst) begin
            nx.conn = 1'b0;
            nx.ls   = 1'b0;
            nx.en   = 1'b0;
            if (st.conn) nx.csc = 1'b1;
            if (st.en)   nx.pec = 1'b1;
        end else if (sample_en) begin
            if (attach != st.conn) begin
                nx.conn = attach;
                nx.csc  = 1'b1;
                nx.en   = 1'b0;
                if (st.en) nx.pec = 1'b1;
            end
            nx.ls = attach & lowspd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    p_forced_off_r6: assert property (@(posedge clk) disable iff (rst)
        host_rst |=> !st.conn && !st.en && !st.ls);
    p_conn_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rst && st.conn) |=> st.csc);
    p_en_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (host_rst && st.en) |=> st.pec);
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!sample_en && !host_rst) |=> $stable(st.conn) && $stable(st.ls));
    p_susp_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (host_rst && !wr_sel) |=> $stable(st.susp));
    p_ls_attached_r10: assert property (@(posedge clk) disable iff (rst)
        st.ls |-> st.conn);
    p_en_attached_r5: assert property (@(posedge clk) disable iff (rst)
        st.en |-> st.conn);

endmodule

// File: rtl/rh_port_bank.sv
module rh_port_bank
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS    = 2,
    parameter int DETECT_TICKS = 64,
    localparam int ADDR_W      = $clog2(NUM_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_rst,
    input  logic                 bit_tick,
    input  logic [NUM_PORTS-1:0] attach_in,
    input  logic [NUM_PORTS-1:0] lowspd_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata
);
    logic                 sample_en;
    logic [NUM_PORTS-1:0] wr_sel;
    port_st_t             st [NUM_PORTS];

    rh_redetect_timer #(.DETECT_TICKS(DETECT_TICKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .host_rst  (host_rst),
        .bit_tick  (bit_tick),
        .sample_en (sample_en)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign wr_sel[g] = reg_wr && (reg_addr == ADDR_W'(g));

        rh_port_status u_port (
            .clk       (clk),
            .rst       (rst),
            .host_rst  (host_rst),
            .sample_en (sample_en),
            .attach    (attach_in[g]),
            .lowspd    (lowspd_in[g]),
            .wr_sel    (wr_sel[g]),
            .wdata     (reg_wdata),
            .st        (st[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (reg_addr == ADDR_W'(i)) reg_rdata = to_word(st[i]);
        end
    end

    p_single_write_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));
    p_unused_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_addr) >= NUM_PORTS) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_rh_port_bank.sv
module sim_rh_port_bank;
    localparam int NP = 3;
    localparam int AW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_rst = 1'b0;
    logic          bit_tick = 1'b0;
    logic [NP-1:0] attach_in = '0;
    logic [NP-1:0] lowspd_in = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rh_port_bank #(.NUM_PORTS(NP), .DETECT_TICKS(64)) u0 (
        .clk(clk), .rst(rst), .host_rst(host_rst), .bit_tick(bit_tick),
        .attach_in(attach_in), .lowspd_in(lowspd_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input int port, input logic [15:0] exp);
        reg_addr = AW'(port);
        #1;
        n_run++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s port %0d: got 0x%04h expected 0x%04h", req, port, reg_rdata, exp);
        end
    endtask

    task automatic wr(input int port, input logic [15:0] d);
        @(negedge clk);
        reg_addr = AW'(port); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic pulse_host_rst(input int cyc);
        @(negedge clk); host_rst = 1'b1;
        repeat (cyc) @(negedge clk);
        host_rst = 1'b0;
    endtask

    task automatic t_reset();
        for (int p = 0; p < NP; p++) check("R1", p, 16'h0000);
    endtask

    task automatic t_attach();
        @(negedge clk); attach_in[0] = 1'b1; lowspd_in[0] = 1'b1;
        @(negedge clk);
        check("R2", 0, 16'h0103);
        check("R11", 1, 16'h0000);
    endtask

    task automatic t_clear();
        wr(0, 16'h0000);
        check("R4", 0, 16'h0103);
        wr(0, 16'h0002);
        check("R4", 0, 16'h0101);
    endtask

    task automatic t_enable();
        wr(1, 16'h0004);
        check("R5", 1, 16'h0000);
        wr(0, 16'h0004);
        check("R5", 0, 16'h0105);
        wr(0, 16'h1004);
        check("R11", 0, 16'h1105);
        check("R11", 1, 16'h0000);
    endtask

    task automatic t_host_reset();
        pulse_host_rst(2);
        check("R6", 0, 16'h100A);
        ticks(63);
        check("R8", 0, 16'h100A);
        ticks(1);
        check("R8", 0, 16'h110B);
    endtask

    task automatic t_restart();
        wr(0, 16'h100A);
        check("R7", 0, 16'h1101);
        pulse_host_rst(1);
        check("R7", 0, 16'h1002);
        ticks(40);
        pulse_host_rst(1);
        ticks(63);
        check("R9", 0, 16'h1002);
        ticks(1);
        check("R9", 0, 16'h1103);
    endtask

    task automatic t_disconnect();
        wr(0, 16'h100E);
        check("R5", 0, 16'h1105);
        @(negedge clk); attach_in[0] = 1'b0;
        @(negedge clk);
        check("R3", 0, 16'h100A);
        check("R10", 0, 16'h100A);
        @(negedge clk); attach_in[2] = 1'b1; lowspd_in[2] = 1'b0;
        @(negedge clk);
        check("R10", 2, 16'h0003);
        check("R11", 3, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_attach();
        t_clear();
        t_enable();
        t_host_reset();
        t_restart();
        t_disconnect();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule